// File: doc/BRIEF.md
# Two-Channel Compare-Match Timer

This peripheral holds two independent 16-bit up-counters. Each counter advances on a tick that comes from a divided peripheral clock. When the counter has reached its programmed compare constant, the next tick reloads it to zero and sets a sticky match flag. If the channel's interrupt enable is set, the channel's interrupt line is raised. A channel therefore produces one match every `constant + 1` ticks. This makes it suitable as a periodic tick source or, once the constant is rewritten, as a single timeout.

Software reaches the block through a simple word-addressed register bus with an address, write data, a write strobe and registered read data. A single shared run-control word holds one start/stop bit per channel. Each channel also has three registers: control/status, counter and compare constant. All channels run from the same clock, and each has its own prescaler.

Top module: `match_timer`

## Requirements
- R1: After reset, the run-control word, every control/status register and every counter read 0x0000. Every compare constant reads 0xFFFF, and every interrupt output is low.
- R2: The bus address is a 16-bit word index, equal to the byte offset divided by 2. Word 0 is the run-control word. Channel n has control/status at word 1+3n, counter at word 2+3n and compare constant at word 3+3n. Read data appears on `rd_data` on the clock edge that follows the cycle the address is presented. This holds for all registers, including a counter that is running.
- R3: Bit n of the run-control word runs (1) or stops (0) channel n. Run-control bits above the channel count read as 0. A stopped channel holds its counter value, and the other channel's bit has no effect on it.
- R4: Control/status bits [1:0] select the tick as the clock divided by 8, 32, 128 or 512, for codes 0, 1, 2 and 3. The first tick after a 0-to-1 start bit comes exactly one full division period later, because stopping a channel resets its prescaler phase.
- R5: On a tick when the counter equals the compare constant, the counter reloads to 0 instead of incrementing.
- R6: The reload tick of R5 sets the match flag, which is control/status bit 7. The flag stays set until software clears it.
- R7: A control/status write with bit 7 at 0 clears the flag, and a write with bit 7 at 1 leaves it unchanged. If a clearing write and a reload tick fall on the same edge, the flag ends up set.
- R8: Control/status bit 6 is the interrupt enable. Interrupt output n is high exactly when channel n's flag and enable are both 1, and it follows them on the same edge.
- R9: A write to the counter loads the written value. On an edge that is also a tick, the write replaces both the increment and the reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| rd_data | output | 16 | Registered read data of the address of the previous cycle |
| irq | output | 2 | Per-channel interrupt level |

## Verification
A prescaler whose phase is wrong moves the counter value read after a stop by one count. This shows within one division period of 8 to 512 clocks. A compare or flag path that is wrong shows on the interrupt line and in control/status bit 7 on the edge of the reload tick. A bad decode or priority shows on the first read-back of the register concerned, one clock after the access. Counts are therefore checked at exact edge offsets from a start, and at the exact clock on either side of the first tick at divide-by-512.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [2:0] {
    RK_NONE  = 3'd0,
    RK_START = 3'd1,
    RK_CTRL  = 3'd2,
    RK_CNT   = 3'd3,
    RK_CMP   = 3'd4
  } reg_kind_e;

  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int REGS_PER_CH = 3;
  localparam int CH_BASE_WORD = 1;

endpackage

// File: rtl/mt_regdec.sv
module mt_regdec
  import mt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              start_we_o,
  output logic [NUM_CH-1:0] ctrl_we_o,
  output logic [NUM_CH-1:0] cnt_we_o,
  output logic [NUM_CH-1:0] cmp_we_o,
  output reg_kind_e         rd_kind_o,
  output logic [CH_W-1:0]   rd_ch_o
);

  logic [NUM_CH-1:0] ctrl_hit, cnt_hit, cmp_hit;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
    localparam int BASE = CH_BASE_WORD + REGS_PER_CH * n;
    assign ctrl_hit[n] = (addr_i == ADDR_W'(BASE));
    assign cnt_hit[n]  = (addr_i == ADDR_W'(BASE + 1));
    assign cmp_hit[n]  = (addr_i == ADDR_W'(BASE + 2));
  end

  assign start_we_o = we_i && (addr_i == '0);
  assign ctrl_we_o  = we_i ? ctrl_hit : '0;
  assign cnt_we_o   = we_i ? cnt_hit  : '0;
  assign cmp_we_o   = we_i ? cmp_hit  : '0;

  always_comb begin
    rd_kind_o = RK_NONE;
    rd_ch_o   = '0;
    if (addr_i == '0) rd_kind_o = RK_START;
    for (int n = 0; n < NUM_CH; n++) begin
      if (ctrl_hit[n]) begin rd_kind_o = RK_CTRL; rd_ch_o = CH_W'(n); end
      if (cnt_hit[n])  begin rd_kind_o = RK_CNT;  rd_ch_o = CH_W'(n); end
      if (cmp_hit[n])  begin rd_kind_o = RK_CMP;  rd_ch_o = CH_W'(n); end
    end
  end

  // R2: a write reaches at most one register
  p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_we_o, ctrl_we_o, cnt_we_o, cmp_we_o}));

endmodule

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int SEL_W    = 2,
  parameter int LOG_BASE = 3,
  parameter int LOG_STEP = 2,
  parameter int PRE_W    = LOG_BASE + LOG_STEP * ((1 << SEL_W) - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  always_comb begin
    lim = PRE_W'((1 << (LOG_BASE + LOG_STEP * int'(sel_i))) - 1);
  end

  assign tick_o = run_i && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      pre_q <= '0;
    end else if (pre_q >= lim) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R4: the smallest division is 8, so two ticks are never adjacent
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

endmodule

// File: rtl/mt_channel.sv
module mt_channel
  import mt_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SEL_W = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          ctrl_we_i,
  input  logic          cnt_we_i,
  input  logic          cmp_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] cmp_o,
  output logic          irq_o
);

  logic             tick;
  logic             hit;
  logic             flag_q, ie_q;
  logic             flag_d, ie_d;
  logic [SEL_W-1:0] cks_q;
  logic [DW-1:0]    cnt_q, cmp_q;

  mt_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run_i),
    .sel_i  (cks_q),
    .tick_o (tick)
  );

  assign hit = tick && (cnt_q == cmp_q) && !cnt_we_i;

  always_comb begin
    flag_d = flag_q;
    ie_d   = ie_q;
    if (ctrl_we_i) begin
      ie_d = wdata_i[IE_BIT];
      if (!wdata_i[FLAG_BIT]) flag_d = 1'b0;
    end
    if (hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      cks_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq_o  <= flag_d && ie_d;
      if (ctrl_we_i) cks_q <= wdata_i[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i;
    end else if (hit) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
    end else if (cmp_we_i) begin
      cmp_q <= wdata_i;
    end
  end

  always_comb begin
    ctrl_o            = '0;
    ctrl_o[FLAG_BIT]  = flag_q;
    ctrl_o[IE_BIT]    = ie_q;
    ctrl_o[SEL_W-1:0] = cks_q;
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;

  // R3: a stopped channel with no counter write keeps its count
  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !cnt_we_i) |=> $stable(cnt_q));

  // R5: the tick that finds counter == constant brings it back to zero
  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt_q == '0));

  // R6: a reload tick leaves the flag set
  p_flag_on_match_r6: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);

  // R7: only a write with bit 7 low can drop the flag
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(ctrl_we_i && !wdata_i[FLAG_BIT])) |=> flag_q);

  // R8: the interrupt rises only after a match or an enable write
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(hit || (ctrl_we_i && wdata_i[IE_BIT])));

  // R9: a counter write lands unchanged, tick or not
  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_we_i |=> (cnt_q == $past(wdata_i)));

endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 16,
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  output logic [DW-1:0]     rd_data,
  output logic [NUM_CH-1:0] irq
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              start_we;
  logic [NUM_CH-1:0] ctrl_we, cnt_we, cmp_we;
  reg_kind_e         rd_kind;
  logic [CH_W-1:0]   rd_ch;
  logic [NUM_CH-1:0] run_q;
  logic [DW-1:0]     ctrl_w [NUM_CH];
  logic [DW-1:0]     cnt_w  [NUM_CH];
  logic [DW-1:0]     cmp_w  [NUM_CH];

  mt_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (bus_addr),
    .we_i       (bus_we),
    .start_we_o (start_we),
    .ctrl_we_o  (ctrl_we),
    .cnt_we_o   (cnt_we),
    .cmp_we_o   (cmp_we),
    .rd_kind_o  (rd_kind),
    .rd_ch_o    (rd_ch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (start_we) begin
      run_q <= bus_wdata[NUM_CH-1:0];
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    mt_channel #(.DW(DW), .SEL_W(SEL_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .run_i     (run_q[n]),
      .ctrl_we_i (ctrl_we[n]),
      .cnt_we_i  (cnt_we[n]),
      .cmp_we_i  (cmp_we[n]),
      .wdata_i   (bus_wdata),
      .ctrl_o    (ctrl_w[n]),
      .cnt_o     (cnt_w[n]),
      .cmp_o     (cmp_w[n]),
      .irq_o     (irq[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_kind)
        RK_START: rd_data <= DW'(run_q);
        RK_CTRL:  rd_data <= ctrl_w[rd_ch];
        RK_CNT:   rd_data <= cnt_w[rd_ch];
        RK_CMP:   rd_data <= cmp_w[rd_ch];
        default:  rd_data <= '0;
      endcase
    end
  end

endmodule

// File: tb/match_timer_tb_top.sv
module match_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int A_START = 0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [15:0] rd_data;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  logic        mon_go = 1'b0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  match_timer dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .rd_data(rd_data), .irq(irq)
  );

  function automatic int a_ctrl(int n); return 1 + 3*n; endfunction
  function automatic int a_cnt(int n);  return 2 + 3*n; endfunction
  function automatic int a_cmp(int n);  return 3 + 3*n; endfunction

  // all tasks are entered at a falling edge and return at the next one
  task automatic wr(input int a, input logic [15:0] d);
    bus_addr = 4'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [15:0] e, input string tag);
    bus_addr = 4'(a); bus_we = 1'b0;
    exp_q.push_back(e); tag_q.push_back(tag);
    mon_go = 1'b1;
    @(negedge clk);
    mon_go = 1'b0;
  endtask

  task automatic chk(input logic [15:0] got, input logic [15:0] e, input string tag);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, e);
    end
  endtask

  // monitor: the edge that samples mon_go also registers the read data
  always @(posedge clk) begin
    if (mon_go) begin
      #1;
      if (exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data, e, t);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    rd(A_START, 16'h0000, "R1 run word");
    rd(a_ctrl(0), 16'h0000, "R1 ctrl0");
    rd(a_cnt(0), 16'h0000, "R1 cnt0");
    rd(a_cmp(0), 16'hFFFF, "R1 cmp0");
    rd(a_cmp(1), 16'hFFFF, "R1 cmp1");
    chk({14'd0, irq}, 16'h0000, "R1 irq");

    // R2 register map and run word width
    wr(a_cmp(0), 16'h1234);
    rd(a_cmp(0), 16'h1234, "R2 cmp0 readback");
    rd(a_cmp(1), 16'hFFFF, "R2 cmp1 untouched");
    wr(a_cmp(0), 16'hFFFF);
    wr(A_START, 16'hFFFC);
    rd(A_START, 16'h0000, "R3 upper run bits");

    // R4 divide by 8: 40 running edges give 5 ticks
    wr(A_START, 16'h0001);
    repeat (39) @(negedge clk);
    wr(A_START, 16'h0000);
    rd(a_cnt(0), 16'd5, "R4 div8 count");
    rd(a_cnt(1), 16'd0, "R3 other channel idle");
    repeat (20) @(negedge clk);
    rd(a_cnt(0), 16'd5, "R3 hold while stopped");

    // R4 phase restarts: two runs of 7 edges never tick
    wr(A_START, 16'h0001);
    repeat (6) @(negedge clk);
    wr(A_START, 16'h0000);
    wr(A_START, 16'h0001);
    repeat (6) @(negedge clk);
    wr(A_START, 16'h0000);
    rd(a_cnt(0), 16'd5, "R4 prescaler phase reset");

    // R4 divide by 32: 64 edges give 2 ticks
    wr(a_cnt(0), 16'h0000);
    wr(a_ctrl(0), 16'h0001);
    wr(A_START, 16'h0001);
    repeat (63) @(negedge clk);
    wr(A_START, 16'h0000);
    rd(a_cnt(0), 16'd2, "R4 div32 count");

    // R4 divide by 512: first tick exactly on edge 512, read while running
    wr(a_cnt(0), 16'h0000);
    wr(a_ctrl(0), 16'h0003);
    wr(A_START, 16'h0001);
    repeat (511) @(negedge clk);
    rd(a_cnt(0), 16'd0, "R4 div512 one edge early");
    rd(a_cnt(0), 16'd1, "R2 live read div512 first tick");
    wr(A_START, 16'h0000);

    // R5 R6 R8 wrap at constant 3 on channel 1
    wr(a_cnt(1), 16'h0000);
    wr(a_cmp(1), 16'h0003);
    wr(a_ctrl(1), 16'h0040);
    wr(A_START, 16'h0002);
    repeat (30) @(negedge clk);
    wr(A_START, 16'h0000);
    rd(a_cnt(1), 16'd3, "R5 at constant");
    rd(a_ctrl(1), 16'h0040, "R6 no flag before reload");
    chk({14'd0, irq}, 16'h0000, "R8 irq low before match");
    wr(A_START, 16'h0002);
    repeat (7) @(negedge clk);
    wr(A_START, 16'h0000);
    rd(a_cnt(1), 16'd0, "R5 reload to zero");
    rd(a_ctrl(1), 16'h00C0, "R6 flag set");
    chk({14'd0, irq}, 16'h0002, "R8 irq follows flag and enable");
    repeat (5) @(negedge clk);
    rd(a_ctrl(1), 16'h00C0, "R6 flag sticky");

    // R7 clear and write-one behaviour
    wr(a_ctrl(1), 16'h0040);
    rd(a_ctrl(1), 16'h0040, "R7 clear by zero");
    chk({14'd0, irq}, 16'h0000, "R8 irq drops with flag");
    wr(a_ctrl(1), 16'h00C0);
    rd(a_ctrl(1), 16'h0040, "R7 write one ignored");

    // R7 clear on the reload edge: flag stays set
    wr(a_cnt(1), 16'h0003);
    wr(A_START, 16'h0002);
    repeat (7) @(negedge clk);
    wr(a_ctrl(1), 16'h0040);
    wr(A_START, 16'h0000);
    rd(a_ctrl(1), 16'h00C0, "R7 match wins over clear");
    rd(a_cnt(1), 16'd0, "R5 reload on collision edge");

    // R8 enable gates the output
    wr(a_ctrl(1), 16'h0080);
    rd(a_ctrl(1), 16'h0080, "R8 enable off, flag kept");
    chk({14'd0, irq}, 16'h0000, "R8 irq low with enable off");
    wr(a_ctrl(1), 16'h00C0);
    chk({14'd0, irq}, 16'h0002, "R8 irq high with enable on");
    wr(a_ctrl(1), 16'h0000);
    chk({14'd0, irq}, 16'h0000, "R8 all-zero write");

    // R9 counter write on a tick edge
    wr(a_ctrl(0), 16'h0000);
    wr(a_cnt(0), 16'h0000);
    wr(A_START, 16'h0001);
    repeat (7) @(negedge clk);
    wr(a_cnt(0), 16'h0100);
    wr(A_START, 16'h0000);
    rd(a_cnt(0), 16'h0100, "R9 write beats increment");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule